// File: doc/BRIEF.md
# Signed Array Multiplier with Weighted Full-Adder Cells

This block multiplies two signed two's complement operands of `N_BITS` bits each and returns their exact signed product on a `2*N_BITS`-bit output. It is purely combinational: the product follows the operands with no clock and no stored state. No complementing stage and no correction row are used. Every partial-product bit keeps the sign of its weight. A bit that involves exactly one operand MSB counts negatively. The MSB-by-MSB bit counts positively.

The summing array is built from four full-adder cell kinds. Each kind fixes which of its inputs and outputs have negative weight. Kinds 0 and 3 share one carry equation, and kinds 1 and 2 share the other. The sum bit is always the XOR of the three inputs. For each operand bit from the second to the next-to-last, one row adds a shifted partial product: plain cells handle the low columns and one mixed-sign cell handles the sign column. The row for the operand MSB subtracts its partial product through a chain of mixed-sign cells that pass negative carries. The array holds `N_BITS*(N_BITS-1)` cells and needs `N_BITS` of at least 3.

Top module: `sarray_mul`

## Requirements
- R1: For every pair of operands, `prod_o` read as a 2*N_BITS-bit two's complement number equals the signed product of `a_i` and `b_i`, for all four sign combinations of the operands.
- R2: When both operands are non-zero, `prod_o[2*N_BITS-1]` equals the XOR of `a_i[N_BITS-1]` and `b_i[N_BITS-1]`.
- R3: When either operand is zero, `prod_o` is all zeros.
- R4: The top two product bits differ only when both operands hold the most negative value (MSB 1, all other bits 0). The product is then +2^(2*N_BITS-2): at N_BITS = 5, 10000 times 10000 gives 0100000000.
- R5: When `b_i` is all ones (-1), `prod_o` is the negation of `a_i` sign-extended to 2*N_BITS bits. This includes the most negative `a_i`, which gives +2^(N_BITS-1).
- R6: When `b_i` is 1, `prod_o` is `a_i` sign-extended to 2*N_BITS bits.
- R7: A kind-0 cell gives 2C + S = X + Y + Z, with S = X xor Y xor Z and C = XY + YZ + ZX.
- R8: A kind-1 cell gives 2C - S = X + Y - Z, with S = X xor Y xor Z and C = XY + YZ' + Z'X.
- R9: A kind-2 cell gives -2C + S = -X - Y + Z, with S = X xor Y xor Z and C = XY + YZ' + Z'X.
- R10: A kind-3 cell gives -2C - S = -X - Y - Z, with S = X xor Y xor Z and C = XY + YZ + ZX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N_BITS | Multiplicand, two's complement |
| b_i | input | N_BITS | Multiplier, two's complement |
| prod_o | output | 2*N_BITS | Signed product, two's complement |

## Verification
For every operand pair the design sees, the bound checker compares the product with the exact signed result. It also checks the sign rule, zero absorption, the identity and negation cases, and the rule that only the most-negative square may separate the top two bits. Those checks cannot show the arithmetic identity of each cell kind in isolation. In particular, kinds 1 and 3 never appear in the array, so the bench drives every cell kind directly through all eight input combinations. The bench also sweeps every operand pair at the default width, which covers all four sign quadrants and their edges.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Which cell inputs/outputs carry negative weight.
    // KIND0: none; KIND1: Z and S; KIND2: X, Y and C; KIND3: all.
    typedef enum logic [1:0] {
        CELL_T0 = 2'd0,
        CELL_T1 = 2'd1,
        CELL_T2 = 2'd2,
        CELL_T3 = 2'd3
    } cell_kind_e;

    // A row either adds a shifted partial product or subtracts it.
    typedef enum logic {
        ROW_ADD = 1'b0,
        ROW_SUB = 1'b1
    } row_kind_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } cell_res_t;

    // Mixed-sign cells see Z with the opposite polarity of X and Y,
    // so their carry majority uses the complement of Z.
    function automatic logic carry_takes_zbar(input cell_kind_e k);
        return (k == CELL_T1) || (k == CELL_T2);
    endfunction

    // The operand-MSB row is the only subtracting row.
    function automatic row_kind_e row_kind_of(input int r, input int n);
        return (r == n - 1) ? ROW_SUB : ROW_ADD;
    endfunction

endpackage

// File: rtl/sam_cell.sv
module sam_cell
    import sam_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_T0
) (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic c_o
);

    localparam logic ZBAR = carry_takes_zbar(KIND);

    logic      zc;
    cell_res_t res;

    generate
        if (ZBAR) begin : g_zbar
            assign zc = ~z_i;
        end else begin : g_zplain
            assign zc = z_i;
        end
    endgenerate

    always_comb begin
        res.sum   = x_i ^ y_i ^ z_i;
        res.carry = (x_i & y_i) | (y_i & zc) | (zc & x_i);
    end

    assign s_o = res.sum;
    assign c_o = res.carry;

endmodule

// File: rtl/sam_ppgen.sv
module sam_ppgen #(
    parameter int N_BITS = 5
) (
    input  logic [N_BITS-1:0]             a_i,
    input  logic [N_BITS-1:0]             b_i,
    output logic [N_BITS-1:0][N_BITS-1:0] pp_o
);

    // pp_o[r][j] has weight 2^(r+j); its sign is set by the summing rows.
    generate
        for (genvar r = 0; r < N_BITS; r++) begin : g_row
            for (genvar j = 0; j < N_BITS; j++) begin : g_col
                assign pp_o[r][j] = a_i[j] & b_i[r];
            end
        end
    endgenerate

endmodule

// File: rtl/sam_row.sv
module sam_row
    import sam_pkg::*;
#(
    parameter int        W    = 5,
    parameter row_kind_e KIND = ROW_ADD
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] pp_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    // acc_i: positive bits except the top one (negative sign bit).
    // ROW_ADD pp_i: positive bits except the top one.
    // ROW_SUB pp_i: negative bits except the top one.
    // Every sum_o bit is positive; cout_o is the new negative sign bit.
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    generate
        for (genvar k = 0; k < W; k++) begin : g_cell
            localparam logic       TOP = (k == W - 1);
            localparam cell_kind_e CK  = (KIND == ROW_ADD && !TOP) ? CELL_T0 : CELL_T2;
            logic xs, ys, zs;

            if (KIND == ROW_ADD) begin : g_add
                // low columns: all positive; top column: two signs + carry
                assign xs = pp_i[k];
                assign ys = acc_i[k];
                assign zs = cy[k];
            end else if (!TOP) begin : g_sub_lo
                // negative pp bit and negative borrow against positive acc bit
                assign xs = pp_i[k];
                assign ys = cy[k];
                assign zs = acc_i[k];
            end else begin : g_sub_top
                // negative acc sign and borrow against positive MSB x MSB bit
                assign xs = acc_i[k];
                assign ys = cy[k];
                assign zs = pp_i[k];
            end

            sam_cell #(
                .KIND(CK)
            ) u_cell (
                .x_i(xs),
                .y_i(ys),
                .z_i(zs),
                .s_o(sum_o[k]),
                .c_o(cy[k+1])
            );
        end
    endgenerate

    assign cout_o = cy[W];

endmodule

// File: rtl/sarray_mul.sv
module sarray_mul
    import sam_pkg::*;
#(
    parameter int N_BITS = 5
) (
    input  logic [N_BITS-1:0]   a_i,
    input  logic [N_BITS-1:0]   b_i,
    output logic [2*N_BITS-1:0] prod_o
);

    localparam int PW = 2 * N_BITS;

    logic [N_BITS-1:0][N_BITS-1:0] pp;
    // win[r] holds accumulator columns r .. r+N_BITS after row r.
    logic [N_BITS-1:0][N_BITS:0]   win;

    sam_ppgen #(
        .N_BITS(N_BITS)
    ) u_ppgen (
        .a_i (a_i),
        .b_i (b_i),
        .pp_o(pp)
    );

    // First row sign-extended by one column: -s*2^(n-1) = s*2^(n-1) - s*2^n.
    assign win[0] = {pp[0][N_BITS-1], pp[0]};

    generate
        for (genvar r = 1; r < N_BITS; r++) begin : g_rows
            sam_row #(
                .W   (N_BITS),
                .KIND(row_kind_of(r, N_BITS))
            ) u_row (
                .acc_i (win[r-1][N_BITS:1]),
                .pp_i  (pp[r]),
                .sum_o (win[r][N_BITS-1:0]),
                .cout_o(win[r][N_BITS])
            );
        end

        for (genvar r = 0; r < N_BITS - 1; r++) begin : g_low
            assign prod_o[r] = win[r][0];
        end
    endgenerate

    assign prod_o[PW-1:N_BITS-1] = win[N_BITS-1];

endmodule

// File: rtl/sarray_mul_chk.sv
module sarray_mul_chk #(
    parameter int N_BITS = 5
) (
    input logic [N_BITS-1:0]   a_i,
    input logic [N_BITS-1:0]   b_i,
    input logic [2*N_BITS-1:0] prod_o
);

    localparam int              PW     = 2 * N_BITS;
    localparam logic [N_BITS-1:0] MIN_OP = {1'b1, {(N_BITS-1){1'b0}}};
    localparam logic [N_BITS-1:0] ONE_OP = {{(N_BITS-1){1'b0}}, 1'b1};

    logic signed [PW-1:0] a_x, b_x, exact;

    always_comb begin
        a_x   = {{N_BITS{a_i[N_BITS-1]}}, a_i};
        b_x   = {{N_BITS{b_i[N_BITS-1]}}, b_i};
        exact = a_x * b_x;

        AST_EXACT_PRODUCT: assert (prod_o == exact) // R1
            else $error("product mismatch");
        if (a_i != '0 && b_i != '0) begin
            AST_SIGN_RULE: assert (prod_o[PW-1] == (a_i[N_BITS-1] ^ b_i[N_BITS-1])) // R2
                else $error("sign rule");
        end
        if (a_i == '0 || b_i == '0) begin
            AST_ZERO_ABSORB: assert (prod_o == '0) // R3
                else $error("zero operand");
        end
        AST_MIN_SQUARE: assert ((prod_o[PW-1] != prod_o[PW-2]) == (a_i == MIN_OP && b_i == MIN_OP)) // R4
            else $error("top bits");
        if (b_i == '1) begin
            AST_NEG_ONE: assert (prod_o == PW'(-a_x)) // R5
                else $error("negation");
        end
        if (b_i == ONE_OP) begin
            AST_UNIT: assert (prod_o == a_x) // R6
                else $error("identity");
        end
    end

endmodule

bind sarray_mul sarray_mul_chk #(
    .N_BITS(N_BITS)
) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod_o)
);

// File: tb/sim_sarray_mul.sv
module sim_sarray_mul;
    import sam_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;
    localparam int PW         = 2 * N;
    localparam int WD_CYCLES  = 20000;

    // {a, b, expected product}
    localparam logic [19:0] VEC_TAB [12] = '{
        20'b00011_00100_0000001100,  //   3 *   4 =   12
        20'b11101_00100_1111110100,  //  -3 *   4 =  -12
        20'b00111_11011_1111011101,  //   7 *  -5 =  -35
        20'b11010_11001_0000101010,  //  -6 *  -7 =   42
        20'b10000_10000_0100000000,  // -16 * -16 =  256
        20'b10000_01111_1100010000,  // -16 *  15 = -240
        20'b01111_01111_0011100001,  //  15 *  15 =  225
        20'b11111_10000_0000010000,  //  -1 * -16 =   16
        20'b00000_10111_0000000000,  //   0 *  -9 =    0
        20'b01011_11111_1111110101,  //  11 *  -1 =  -11
        20'b10000_00001_1111110000,  // -16 *   1 =  -16
        20'b01001_10011_1110001011   //   9 * -13 = -117
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  a_s = '0;
    logic [N-1:0]  b_s = '0;
    logic [PW-1:0] p_s;
    logic          cx = 1'b0, cy = 1'b0, cz = 1'b0;
    logic [3:0]    cs, cc;
    int            checks = 0;
    int            errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sarray_mul #(
        .N_BITS(N)
    ) u0 (
        .a_i   (a_s),
        .b_i   (b_s),
        .prod_o(p_s)
    );

    sam_cell #(.KIND(CELL_T0)) u_k0 (.x_i(cx), .y_i(cy), .z_i(cz), .s_o(cs[0]), .c_o(cc[0]));
    sam_cell #(.KIND(CELL_T1)) u_k1 (.x_i(cx), .y_i(cy), .z_i(cz), .s_o(cs[1]), .c_o(cc[1]));
    sam_cell #(.KIND(CELL_T2)) u_k2 (.x_i(cx), .y_i(cy), .z_i(cz), .s_o(cs[2]), .c_o(cc[2]));
    sam_cell #(.KIND(CELL_T3)) u_k3 (.x_i(cx), .y_i(cy), .z_i(cz), .s_o(cs[3]), .c_o(cc[3]));

    task automatic check_eq(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] av, input logic [N-1:0] bv);
        @(posedge clk);
        a_s = av;
        b_s = bv;
        @(negedge clk);
    endtask

    // Expected {carry, sum} from each kind's weighted identity.
    function automatic logic [1:0] cell_ref(input int kind, input int x, input int y, input int z);
        int v, s, c;
        case (kind)
            0:       begin v = x + y + z;  s = v & 1; c = (v - s) / 2; end
            1:       begin v = x + y - z;  s = v & 1; c = (v + s) / 2; end
            2:       begin v = -x - y + z; s = v & 1; c = (s - v) / 2; end
            default: begin v = x + y + z;  s = v & 1; c = (v - s) / 2; end
        endcase
        return {c[0], s[0]};
    endfunction

    function automatic logic [PW-1:0] sext(input logic [N-1:0] v);
        return {{N{v[N-1]}}, v};
    endfunction

    initial begin
        // bench reset: operands held at zero
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R3 zero product under reset", p_s, '0);
        rst = 1'b0;

        // vector table (R1, all sign quadrants)
        for (int k = 0; k < 12; k++) begin
            drive(VEC_TAB[k][19:15], VEC_TAB[k][14:10]);
            check_eq($sformatf("R1 table entry %0d", k), p_s, VEC_TAB[k][9:0]);
        end

        // exhaustive sweep (R1 value, R2 sign)
        for (int ia = -(1 << (N-1)); ia < (1 << (N-1)); ia++) begin
            for (int ib = -(1 << (N-1)); ib < (1 << (N-1)); ib++) begin
                int prod;
                drive(N'(ia), N'(ib));
                prod = ia * ib;
                check_eq($sformatf("R1 %0d*%0d", ia, ib), p_s, PW'(prod));
                if (ia != 0 && ib != 0)
                    check_eq($sformatf("R2 sign %0d*%0d", ia, ib), PW'(p_s[PW-1]),
                             PW'((ia < 0) != (ib < 0)));
            end
        end

        // R3 zero absorption against extreme operands
        drive(5'b10000, 5'b00000);
        check_eq("R3 min*0", p_s, '0);
        drive(5'b00000, 5'b01111);
        check_eq("R3 0*max", p_s, '0);

        // R4 only min*min separates the top two bits
        drive(5'b10000, 5'b10000);
        check_eq("R4 min*min", p_s, 10'b0100000000);
        drive(5'b10001, 5'b10000);
        check_eq("R4 near-min top bits", PW'(p_s[PW-1] ^ p_s[PW-2]), '0);

        // R5 multiply by -1
        drive(5'b10000, 5'b11111);
        check_eq("R5 min*-1", p_s, 10'b0000010000);
        drive(5'b00111, 5'b11111);
        check_eq("R5 7*-1", p_s, 10'b1111111001);

        // R6 multiply by +1
        drive(5'b10111, 5'b00001);
        check_eq("R6 -9*1", p_s, sext(5'b10111));
        drive(5'b01110, 5'b00001);
        check_eq("R6 14*1", p_s, sext(5'b01110));

        // R7..R10 each cell kind over all inputs
        for (int v = 0; v < 8; v++) begin
            @(posedge clk);
            cx = v[2]; cy = v[1]; cz = v[0];
            @(negedge clk);
            check_eq($sformatf("R7 kind0 xyz=%03b", v[2:0]), PW'({cc[0], cs[0]}),
                     PW'(cell_ref(0, int'(v[2]), int'(v[1]), int'(v[0]))));
            check_eq($sformatf("R8 kind1 xyz=%03b", v[2:0]), PW'({cc[1], cs[1]}),
                     PW'(cell_ref(1, int'(v[2]), int'(v[1]), int'(v[0]))));
            check_eq($sformatf("R9 kind2 xyz=%03b", v[2:0]), PW'({cc[2], cs[2]}),
                     PW'(cell_ref(2, int'(v[2]), int'(v[1]), int'(v[0]))));
            check_eq($sformatf("R10 kind3 xyz=%03b", v[2:0]), PW'({cc[3], cs[3]}),
                     PW'(cell_ref(3, int'(v[2]), int'(v[1]), int'(v[0]))));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d cycles expected=below %0d", WD_CYCLES, WD_CYCLES);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule